// File: doc/BRIEF.md
# Snapshot Integration and Correlated-Sampling Strobe Sequencer

This block produces the global control strobes that a snapshot-mode pixel array needs once per frame. Every pixel is reset, integrates and is sampled at the same moment. After that, a separate readout engine drains the array row by row. For each accepted frame start the sequencer runs a fixed sequence. It pulses the pixel reset, fires one reset-level hold strobe, holds integrate enable for a programmed number of cycles, and fires the integrated-level hold strobe. Last, it hands the frame to the readout engine with a one-cycle start pulse.

Two hold paths store the reset level, and they take turns. Odd frames use one path and even frames use the other. An internal parity bit picks the path and flips on every accepted frame. The parity is also reported with the readout start pulse, so the readout side knows which reset path belongs to the frame it drains. This ping-pong lets the sequencer work in either of two modes. In sequential mode a new frame waits until the readout engine is idle. In overlapped mode the next frame integrates while the previous one is still being read out. The integrated-level path is shared by all frames.

The integration length is given in steps of `STEP_NS` nanoseconds. Each step becomes `STEP_CYC = ceil(STEP_NS * CLK_MHZ / 1000)` clock cycles. With the defaults (100 ns, 5 MHz) one step is one cycle.

Top module: `snap_cds_seq`

States: `ST_IDLE` (waiting for an accepted start), `ST_PIXRST` (pixel reset, 2 cycles), `ST_SAMPRST` (reset-level strobe, 1 cycle), `ST_INTEG` (integration, N cycles), `ST_SAMPSIG` (integrated-level strobe, 1 cycle) and `ST_HANDOFF` (readout start, 1 cycle).

Transitions: `ST_IDLE` moves to `ST_PIXRST` on acceptance. `ST_PIXRST` moves to `ST_SAMPRST` when its counter expires. `ST_SAMPRST` always moves to `ST_INTEG`. `ST_INTEG` moves to `ST_SAMPSIG` when its counter expires. `ST_SAMPSIG` always moves to `ST_HANDOFF`, and `ST_HANDOFF` always returns to `ST_IDLE`.

## Requirements
- R1: While reset is asserted and right after it, all strobes, `frame_odd`, `readout_start` and `readout_odd` are 0 and the block is idle.
- R2: Each accepted frame flips `frame_odd` on the same edge that starts the sequence, so the first frame after reset is odd (`frame_odd`=1).
- R3: In the cycle after the accepting edge, `pix_rst` goes high for exactly 2 cycles. One reset-level strobe cycle follows, then N cycles of `integrate_en`.
- R4: The reset-level strobe appears on `sh_rst_odd` when `frame_odd`=1 and on `sh_rst_even` when `frame_odd`=0. The two are never high together.
- R5: `sh_sig` is high for exactly one cycle on every frame, in the cycle after the last `integrate_en` cycle.
- R6: N = max(`int_len`,1) × `STEP_CYC`, so a programmed length of 0 integrates for one step.
- R7: `readout_start` pulses for one cycle in the cycle after `sh_sig`. During that cycle `readout_odd` equals the parity of the frame just finished. At all other times `readout_odd` is 0.
- R8: With `mode_iwr`=0, a frame start seen while `readout_busy`=1 is held pending. It is accepted on the first idle edge at which `readout_busy`=0.
- R9: With `mode_iwr`=1, `readout_busy` has no effect, and a frame start seen while idle is accepted on that edge.
- R10: Frame starts that arrive while a sequence runs are remembered. However many arrive, they merge into exactly one further sequence, which is accepted on the first idle edge after `ST_HANDOFF` that meets R8/R9.
- R11: `int_len` is sampled only at the accepting edge. Changing it during a frame does not change that frame's N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_iwr | input | 1 | 1 = overlapped integrate-while-read, 0 = sequential |
| int_len | input | LEN_W | Integration length in steps |
| frame_start | input | 1 | Frame request pulse |
| readout_busy | input | 1 | Readout engine still draining a frame |
| pix_rst | output | 1 | Global pixel reset |
| integrate_en | output | 1 | Global integrate enable |
| sh_rst_odd | output | 1 | Reset-level hold strobe, odd-frame path |
| sh_rst_even | output | 1 | Reset-level hold strobe, even-frame path |
| sh_sig | output | 1 | Integrated-level hold strobe |
| frame_odd | output | 1 | Parity of the most recently accepted frame |
| readout_start | output | 1 | One-cycle hand-off to the readout engine |
| readout_odd | output | 1 | Parity of the frame handed off |

## Verification
The hardest state to reach from the ports is a pending request that meets a sequence still in progress. This happens in two ways. Several starts can arrive during one frame and must merge into exactly one follow-up frame. Or, in sequential mode, a start can arrive while busy is high and must wait for busy to fall, even though other frames are already queued behind the running sequence. Directed cases pulse starts in the middle of integration and raise busy before a request. A long random phase then draws start pulses, busy toggles, mode flips and length changes mid-frame at high enough rates that these collisions recur many times. Every output is compared each cycle with a phase-counting reference model in the bench.

// File: rtl/snap_cds_pkg.sv
package snap_cds_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PIXRST,
        ST_SAMPRST,
        ST_INTEG,
        ST_SAMPSIG,
        ST_HANDOFF
    } seq_state_t;

    // Pixel reset pulse length in cycles.
    localparam int RST_CYC = 2;

endpackage

// File: rtl/snap_len_scale.sv
// Turns a step count into integration cycles, treating 0 as one step.
module snap_len_scale #(
    parameter int LEN_W    = 8,
    parameter int STEP_CYC = 1,
    parameter int CNT_W    = 8
) (
    input  logic [LEN_W-1:0] len,
    output logic [CNT_W-1:0] ncyc
);
    logic [LEN_W-1:0] eff_len;

    always_comb begin
        eff_len = (len == '0) ? LEN_W'(1) : len;
        ncyc    = CNT_W'(eff_len) * CNT_W'(STEP_CYC);
    end
endmodule

// File: rtl/snap_cycle_timer.sv
// Down-counter that can be loaded; it holds at zero once it gets there.
module snap_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/snap_start_gate.sv
// Remembers frame requests and decides when one is accepted.
module snap_start_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic readout_busy,
    input  logic mode_iwr,
    input  logic idle,
    output logic accept
);
    logic pend_q;
    logic req;

    assign req    = frame_start | pend_q;
    assign accept = idle & req & (mode_iwr | ~readout_busy);

    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else
            pend_q <= req & ~accept;
    end
endmodule

// File: rtl/snap_cds_seq.sv
module snap_cds_seq
    import snap_cds_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int CLK_MHZ = 5,
    parameter int STEP_NS = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_iwr,
    input  logic [LEN_W-1:0] int_len,
    input  logic             frame_start,
    input  logic             readout_busy,
    output logic             pix_rst,
    output logic             integrate_en,
    output logic             sh_rst_odd,
    output logic             sh_rst_even,
    output logic             sh_sig,
    output logic             frame_odd,
    output logic             readout_start,
    output logic             readout_odd
);
    // Each step becomes a whole number of cycles, rounded up.
    localparam int STEP_CYC = (STEP_NS * CLK_MHZ + 999) / 1000;
    localparam int MAX_CYC  = ((1 << LEN_W) - 1) * STEP_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    seq_state_t       state_q, state_d;
    logic             parity_q;
    logic [CNT_W-1:0] ncyc_q, ncyc_now;
    logic             accept, idle, tmr_zero, tmr_load;
    logic [CNT_W-1:0] tmr_val;

    assign idle = (state_q == ST_IDLE);

    snap_start_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .readout_busy (readout_busy),
        .mode_iwr     (mode_iwr),
        .idle         (idle),
        .accept       (accept)
    );

    snap_len_scale #(
        .LEN_W    (LEN_W),
        .STEP_CYC (STEP_CYC),
        .CNT_W    (CNT_W)
    ) u_scale (
        .len  (int_len),
        .ncyc (ncyc_now)
    );

    snap_cycle_timer #(
        .W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // State register, plus the frame parity and the length latched at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            parity_q <= 1'b0;
            ncyc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                parity_q <= ~parity_q;
                ncyc_q   <= ncyc_now;
            end
        end
    end

    // Next state and timer loads.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d  = ST_PIXRST;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(RST_CYC - 1);
                end
            end
            ST_PIXRST: begin
                if (tmr_zero) state_d = ST_SAMPRST;
            end
            ST_SAMPRST: begin
                state_d  = ST_INTEG;
                tmr_load = 1'b1;
                tmr_val  = ncyc_q - CNT_W'(1);
            end
            ST_INTEG: begin
                if (tmr_zero) state_d = ST_SAMPSIG;
            end
            ST_SAMPSIG: state_d = ST_HANDOFF;
            ST_HANDOFF: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Output decode from the state (Moore).
    always_comb begin
        pix_rst       = 1'b0;
        integrate_en  = 1'b0;
        sh_rst_odd    = 1'b0;
        sh_rst_even   = 1'b0;
        sh_sig        = 1'b0;
        readout_start = 1'b0;
        readout_odd   = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_PIXRST:  pix_rst = 1'b1;
            ST_SAMPRST: begin
                sh_rst_odd  = parity_q;
                sh_rst_even = ~parity_q;
            end
            ST_INTEG:   integrate_en = 1'b1;
            ST_SAMPSIG: sh_sig = 1'b1;
            ST_HANDOFF: begin
                readout_start = 1'b1;
                readout_odd   = parity_q;
            end
            default: ;
        endcase
    end

    assign frame_odd = parity_q;
endmodule

// File: rtl/snap_cds_seq_chk.sv
module snap_cds_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_iwr,
    input logic readout_busy,
    input logic pix_rst,
    input logic integrate_en,
    input logic sh_rst_odd,
    input logic sh_rst_even,
    input logic sh_sig,
    input logic frame_odd,
    input logic readout_start,
    input logic readout_odd
);
    assert_parity_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_rst) |-> (frame_odd != $past(frame_odd)));

    assert_rst_then_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pix_rst) |-> (sh_rst_odd || sh_rst_even));

    assert_rst_min_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_rst) |=> pix_rst);

    assert_path_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_rst_odd && sh_rst_even));

    assert_odd_path_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sh_rst_odd |-> frame_odd);

    assert_even_path_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sh_rst_even |-> !frame_odd);

    assert_sig_after_integ_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(integrate_en) |-> sh_sig);

    assert_handoff_after_sig_R7: assert property (@(posedge clk) disable iff (!rst_n)
        readout_start |-> $past(sh_sig));

    assert_handoff_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        readout_start |-> (readout_odd == frame_odd));

    assert_odd_only_in_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        readout_odd |-> readout_start);

    assert_wait_for_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pix_rst) && !$past(mode_iwr)) |-> !$past(readout_busy));
endmodule

bind snap_cds_seq snap_cds_seq_chk u_chk (.*);

// File: tb/snap_cds_seq_test.sv
`timescale 1ns/1ps
module snap_cds_seq_test;
    localparam int LEN_W = 8;
    // 100 ns step at 5 MHz -> ceil(0.5) = 1 cycle per step.
    localparam int STEP = (100 * 5 + 999) / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_iwr = 1'b0;
    logic [LEN_W-1:0] int_len = '0;
    logic frame_start = 1'b0;
    logic readout_busy = 1'b0;
    logic pix_rst, integrate_en, sh_rst_odd, sh_rst_even, sh_sig;
    logic frame_odd, readout_start, readout_odd;

    always #2 clk = ~clk;

    snap_cds_seq #(.LEN_W(LEN_W), .CLK_MHZ(5), .STEP_NS(100)) uut (
        .clk(clk), .rst_n(rst_n), .mode_iwr(mode_iwr), .int_len(int_len),
        .frame_start(frame_start), .readout_busy(readout_busy),
        .pix_rst(pix_rst), .integrate_en(integrate_en),
        .sh_rst_odd(sh_rst_odd), .sh_rst_even(sh_rst_even), .sh_sig(sh_sig),
        .frame_odd(frame_odd), .readout_start(readout_start),
        .readout_odd(readout_odd)
    );

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    task automatic chk(string tag, string what, int act, int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Reference model: the phase within a frame, counted from 1.
    int unsigned m_ph = 0;
    int unsigned m_n = 1;
    bit m_par = 0, m_pend = 0;

    always @(posedge clk) begin
        bit acc;
        if (!rst_n) begin
            m_ph <= 0; m_par <= 0; m_pend <= 0; m_n <= 1;
        end else begin
            acc = (m_ph == 0) && (frame_start || m_pend) && (mode_iwr || !readout_busy);
            m_pend <= (m_pend || frame_start) && !acc;
            if (acc) begin
                m_ph  <= 1;
                m_par <= ~m_par;
                m_n   <= ((int_len == 0) ? 1 : int_len) * STEP;
            end else if (m_ph != 0) begin
                m_ph <= (m_ph == 5 + m_n) ? 0 : m_ph + 1;
            end
        end
    end

    function automatic bit e_rst();  return m_ph == 1 || m_ph == 2; endfunction
    function automatic bit e_srst(); return m_ph == 3; endfunction
    function automatic bit e_int();  return m_ph >= 4 && m_ph <= 3 + m_n; endfunction
    function automatic bit e_sig();  return m_ph != 0 && m_ph == 4 + m_n; endfunction
    function automatic bit e_done(); return m_ph != 0 && m_ph == 5 + m_n; endfunction

    bit cmp_on = 0;
    int ig_cnt = 0, last_ig = 0, frames = 0;

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R2", "frame_odd", frame_odd, m_par);
            chk("R3", "pix_rst", pix_rst, e_rst());
            chk("R4", "sh_rst_odd", sh_rst_odd, e_srst() && m_par);
            chk("R4", "sh_rst_even", sh_rst_even, e_srst() && !m_par);
            chk("R6", "integrate_en", integrate_en, e_int());
            chk("R5", "sh_sig", sh_sig, e_sig());
            chk("R7", "readout_start", readout_start, e_done());
            chk("R7", "readout_odd", readout_odd, e_done() && m_par);
        end
        if (pix_rst) ig_cnt = 0;
        else if (integrate_en) ig_cnt++;
        if (readout_start) begin
            last_ig = ig_cnt;
            frames++;
        end
    end

    task automatic pulse_fs();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_ph != 0 || m_pend) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int f0;
        int unsigned seed;
        seed = 32'd1357;
        void'($urandom(seed));
        // R1: state during and right after reset.
        repeat (3) @(negedge clk);
        chk("R1", "pix_rst in reset", pix_rst, 0);
        chk("R1", "frame_odd in reset", frame_odd, 0);
        chk("R1", "readout_start in reset", readout_start, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "strobes after reset",
            {pix_rst, integrate_en, sh_rst_odd, sh_rst_even, sh_sig, readout_odd}, 0);
        cmp_on = 1;

        // R2/R4: the first frame is odd; zero length clamps to one step (R6).
        mode_iwr = 0; int_len = 0;
        pulse_fs();
        chk("R2", "first frame parity", frame_odd, 1);
        wait_idle();
        chk("R6", "zero length integration cycles", last_ig, STEP);

        // R11: a length change mid-frame is ignored.
        int_len = 5;
        pulse_fs();
        repeat (3) @(negedge clk);
        int_len = 50;
        wait_idle();
        chk("R11", "latched length", last_ig, 5 * STEP);

        // R8: sequential mode waits for busy to fall.
        mode_iwr = 0; readout_busy = 1; int_len = 3;
        pulse_fs();
        repeat (8) @(negedge clk);
        chk("R8", "held while busy", pix_rst, 0);
        readout_busy = 0;
        @(negedge clk);
        chk("R8", "start after busy falls", pix_rst, 1);
        wait_idle();

        // R9: overlapped mode ignores busy.
        mode_iwr = 1; readout_busy = 1; int_len = 4;
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        chk("R9", "immediate start while busy", pix_rst, 1);
        wait_idle();
        readout_busy = 0;

        // R10: starts during a frame merge into a single follow-up frame.
        f0 = frames;
        int_len = 6;
        pulse_fs();
        repeat (4) @(negedge clk);
        pulse_fs();
        repeat (2) @(negedge clk);
        pulse_fs();
        wait_idle();
        chk("R10", "frames from merged starts", frames - f0, 2);

        // Random phase.
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            frame_start = ($urandom % 12) == 0;
            if (($urandom % 8) == 0) readout_busy = ~readout_busy;
            if (($urandom % 300) == 0) mode_iwr = ~mode_iwr;
            if (($urandom % 10) == 0)
                int_len = (($urandom % 4) == 0) ? LEN_W'($urandom % 256) : LEN_W'($urandom % 6);
        end
        frame_start = 0; readout_busy = 0;
        wait_idle();

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule